// File: doc/BRIEF.md
# Latched One-Shot Interval Timer

This block is a 16-bit down-counter with a 16-bit reload latch behind it. Software reaches it through a byte-wide register bus with four addresses, with read and write strobes that are sampled on the system clock. Software first puts a low byte into the latch. It then writes the high byte to the counter's high address. That single write fills the whole counter, records the high byte in the latch and starts a timing run. The counter then steps down once per clock.

When a run reaches a count of zero, the block raises a timer flag. It raises only one flag per run. The counter keeps wrapping downward afterwards, but it raises no further flag until the next high-byte load. The flag drives an active-low interrupt line that is gated by an enable input. A 2-bit mode input stands in for two control bits. When the upper bit is set at load time, an active-low pulse output is held low for the whole run. The flag is cleared either by writing the high latch or by reading the low counter byte.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the flag is 0, irq_n and pulse_n are 1, and both latch addresses read back 0.
- R2: A write to address 0 (counter low) or address 2 (latch low) stores the byte in the low latch only. The running count and the expiry time of a run in progress are not changed, and reading address 2 returns the byte.
- R3: A write to address 1 (counter high) loads the counter with {written byte, low latch} and stores the byte in the high latch. In the cycle after the write, addresses 0 and 1 read back the loaded value.
- R4: Once loaded, the count falls by exactly one per clock and wraps from 0000 to FFFF.
- R5: For a loaded value N, the flag becomes 1 exactly N+1 clocks after the load edge, that is on the edge after the cycle in which the count reads zero. It does not rise again when the count wraps back through zero without a new load.
- R6: A write to address 3 (latch high) clears the flag and updates the high latch, which reads back at address 3.
- R7: A read strobe at address 0 clears the flag. Read strobes at addresses 1, 2 and 3 leave it set.
- R8: A write to address 3 neither loads the counter nor starts a run, so no flag and no pulse follow it.
- R9: If mode[1] is 1 at the load, pulse_n is 0 from the load edge until the edge that sets the flag, and is 1 otherwise. With mode[1] equal to 0, pulse_n stays 1. mode[0] has no effect on timing.
- R10: irq_n is 0 exactly when the flag is 1 and irq_en is 1.
- R11: rd_data shows the current count bytes at addresses 0 (low) and 1 (high), and the latch bytes at addresses 2 (low) and 3 (high), combinationally from sel.
- R12: If a flag clear arrives in the same cycle as the zero count of an active run, the flag is set. A new load at address 1 clears the flag and restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register address: 0 count low, 1 count high, 2 latch low, 3 latch high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte selected by sel |
| mode | input | 2 | Bit 1 enables the run pulse; bit 0 unused here |
| irq_en | input | 1 | Interrupt enable |
| timer_flag | output | 1 | Timer expiry flag |
| irq_n | output | 1 | Active-low interrupt request |
| pulse_n | output | 1 | Active-low pulse for the length of a run |

## Verification
On every cycle, the assertions check that the count either takes the load value or falls by exactly one. They also check that every zero count of an armed run raises the flag, that the flag never rises without such an expiry, that the pulse only falls on a load with the pulse mode, and that low-latch writes leave the high latch alone. The exact expiry cycle for varied load values is only shown by the bench scenarios. The same holds for the single flag across a full counter wrap, for which reads clear the flag and which do not, and for the set-beats-clear collision.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'b00,
        SEL_CNT_HI = 2'b01,
        SEL_LAT_LO = 2'b10,
        SEL_LAT_HI = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/oneshot_regs.sv
module oneshot_regs
    import ostmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            sel,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic [2*BYTE_W-1:0]   count,
    output logic [BYTE_W-1:0]     rd_data,
    output logic                  load,
    output logic [2*BYTE_W-1:0]   load_val,
    output logic                  flag_clr
);
    typedef struct packed {
        logic [BYTE_W-1:0] lat_lo;
        logic [BYTE_W-1:0] lat_hi;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel_e;

    assign sel_e = reg_sel_e'(sel);

    always_comb begin
        r_d      = r_q;
        load     = 1'b0;
        flag_clr = 1'b0;
        if (wr_en) begin
            unique case (sel_e)
                SEL_CNT_LO, SEL_LAT_LO: r_d.lat_lo = wr_data;
                SEL_CNT_HI: begin
                    r_d.lat_hi = wr_data;
                    load       = 1'b1;
                end
                SEL_LAT_HI: begin
                    r_d.lat_hi = wr_data;
                    flag_clr   = 1'b1;
                end
                default: ;
            endcase
        end
        if (rd_en && sel_e == SEL_CNT_LO) flag_clr = 1'b1;
        load_val = {wr_data, r_q.lat_lo};
        unique case (sel_e)
            SEL_CNT_LO: rd_data = count[BYTE_W-1:0];
            SEL_CNT_HI: rd_data = count[2*BYTE_W-1:BYTE_W];
            SEL_LAT_LO: rd_data = r_q.lat_lo;
            default:    rd_data = r_q.lat_hi;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // A low-byte write never touches the high latch
    assert_lo_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel_e == SEL_CNT_LO || sel_e == SEL_LAT_LO)) |=> $stable(r_q.lat_hi));

    // A high-latch write does not start a run
    assert_lathi_noload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_e == SEL_LAT_HI) |-> !load);
endmodule

// File: rtl/oneshot_counter.sv
module oneshot_counter #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [2*BYTE_W-1:0]   load_val,
    output logic [2*BYTE_W-1:0]   count,
    output logic                  expire
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        expire = c_q.armed && (c_q.cnt == '0);
        if (load) begin
            c_d.cnt   = load_val;
            c_d.armed = 1'b1;
        end else begin
            c_d.cnt = c_q.cnt - ONE;
            if (expire) c_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((count + ONE) == $past(count)));
endmodule

// File: rtl/oneshot_flag.sv
module oneshot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic expire,
    input  logic flag_clr,
    input  logic pulse_en,
    input  logic irq_en,
    output logic flag,
    output logic irq_n,
    output logic pulse_n
);
    typedef struct packed {
        logic flag;
        logic pulse_low;
    } fl_t;

    fl_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (flag_clr) f_d.flag = 1'b0;
        if (expire)   f_d.flag = 1'b1;
        if (expire)   f_d.pulse_low = 1'b0;
        if (start) begin
            f_d.flag      = 1'b0;
            f_d.pulse_low = pulse_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flag    = f_q.flag;
    assign pulse_n = ~f_q.pulse_low;
    assign irq_n   = ~(f_q.flag & irq_en);

    // Expiry without a reload (and with a clear in the same cycle) sets the flag
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> flag);

    assert_flag_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));

    assert_pulse_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_n) |-> $past(start && pulse_en));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        mode,
    input  logic              irq_en,
    output logic              timer_flag,
    output logic              irq_n,
    output logic              pulse_n
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic             expire;
    logic             flag_clr;
    logic             unused_mode_bit;

    assign unused_mode_bit = mode[0];

    oneshot_regs #(.BYTE_W(BYTE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .count(count), .rd_data(rd_data), .load(load),
        .load_val(load_val), .flag_clr(flag_clr)
    );

    oneshot_counter #(.BYTE_W(BYTE_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .count(count), .expire(expire)
    );

    oneshot_flag flag_i (
        .clk(clk), .rst_n(rst_n), .start(load), .expire(expire),
        .flag_clr(flag_clr), .pulse_en(mode[1]), .irq_en(irq_en),
        .flag(timer_flag), .irq_n(irq_n), .pulse_n(pulse_n)
    );
endmodule

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb_top;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [1:0]  md;
        logic [16:0] exp_k;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h05, 8'h00, 2'b00, 17'd6},
        '{8'h00, 8'h01, 2'b10, 17'd257},
        '{8'h2A, 8'h00, 2'b10, 17'd43},
        '{8'h00, 8'h00, 2'b00, 17'd1},
        '{8'hFF, 8'h00, 2'b01, 17'd256},
        '{8'h10, 8'h01, 2'b11, 17'd273}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [1:0] mode = 2'b00;
    logic       irq_en = 1'b0;
    logic       timer_flag, irq_n, pulse_n;
    int         total = 0;
    int         bad = 0;

    always #(CLK_P/2) clk = ~clk;

    oneshot_timer dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .mode(mode), .irq_en(irq_en),
        .timer_flag(timer_flag), .irq_n(irq_n), .pulse_n(pulse_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_strobe(input logic [1:0] s);
        sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        sel = s; #1; v = rd_data;
    endtask

    task automatic wait_flag(input int k0, output int k);
        k = k0;
        while (!timer_flag && k < 70000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 flag", timer_flag, 0);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 pulse_n", pulse_n, 1);
        peek(2'd2, v); chk("R1 latlo", v, 0);
        peek(2'd3, v); chk("R1 lathi", v, 0);

        // Table walk: R3 R5 R9 (mode[0] ignored)
        for (int i = 0; i < 6; i++) begin
            mode = VEC[i].md;
            wr(2'd2, VEC[i].lo);
            wr(2'd1, VEC[i].hi);
            peek(2'd1, v); chk("R3 cnt hi", v, VEC[i].hi);
            peek(2'd3, v); chk("R3 lat hi", v, VEC[i].hi);
            peek(2'd0, v); chk("R3 cnt lo", v, VEC[i].lo);
            chk("R9 pulse at load", pulse_n, !VEC[i].md[1]);
            wait_flag(0, k);
            chk("R5 expiry cycle", k, VEC[i].exp_k);
            chk("R9 pulse after expiry", pulse_n, 1);
        end

        // R4 decrement and wrap
        mode = 2'b00;
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h00);
        for (int j = 0; j < 4; j++) begin
            peek(2'd0, v); chk("R4 count lo", v, 8'(3 - j));
            @(negedge clk);
        end
        peek(2'd0, v); chk("R4 wrap lo", v, 8'hFF);
        peek(2'd1, v); chk("R4 wrap hi", v, 8'hFF);

        // R10 / R7 with flag set
        chk("R5 flag set", timer_flag, 1);
        irq_en = 1'b0; #1; chk("R10 irq masked", irq_n, 1);
        irq_en = 1'b1; #1; chk("R10 irq active", irq_n, 0);
        rd_strobe(2'd1); chk("R7 hi read keeps", timer_flag, 1);
        rd_strobe(2'd2); chk("R7 latlo read keeps", timer_flag, 1);
        rd_strobe(2'd3); chk("R7 lathi read keeps", timer_flag, 1);
        rd_strobe(2'd0); chk("R7 lo read clears", timer_flag, 0);
        chk("R10 irq released", irq_n, 1);

        // R6 clear via high-latch write
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h00);
        wait_flag(0, k);
        chk("R6 flag before", timer_flag, 1);
        wr(2'd3, 8'hA7);
        chk("R6 cleared", timer_flag, 0);
        peek(2'd3, v); chk("R11 lathi read", v, 8'hA7);

        // R2 low write during a run keeps expiry
        wr(2'd2, 8'h0A);
        wr(2'd1, 8'h00);
        @(negedge clk); @(negedge clk);
        wr(2'd0, 8'h55);
        wait_flag(3, k);
        chk("R2 expiry unchanged", k, 11);
        peek(2'd2, v); chk("R2 latlo", v, 8'h55);

        // R12 clear collides with zero count
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h00);
        chk("R12 reload clears", timer_flag, 0);
        @(negedge clk); @(negedge clk);
        wr(2'd3, 8'h00);
        chk("R12 set beats clear", timer_flag, 1);

        // R8 high-latch write starts nothing
        rd_strobe(2'd0);
        mode = 2'b10;
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h00);
        begin
            int seen_flag = 0;
            int seen_pulse = 0;
            for (int j = 0; j < 20; j++) begin
                if (timer_flag) seen_flag++;
                if (!pulse_n) seen_pulse++;
                @(negedge clk);
            end
            chk("R8 no flag", seen_flag, 0);
            chk("R8 no pulse", seen_pulse, 0);
        end

        // R5 single flag across a full wrap
        mode = 2'b00;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R5 zero load", timer_flag, 1);
        rd_strobe(2'd0);
        begin
            int again = 0;
            for (int j = 0; j < 70000; j++) begin
                if (timer_flag) again++;
                @(negedge clk);
            end
            chk("R5 no second flag", again, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule